// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Array

This block holds the instructions that are waiting for one class of functional unit in an out-of-order core. Each slot keeps an opcode, two operand values, two producer tags and a busy flag. A producer tag of zero means the operand value is already present. A nonzero tag names the station whose result will supply that operand. The front end offers one instruction per cycle on the issue port, with the producer tags and values it has already looked up. The block places the instruction in the lowest-numbered free slot, or refuses it when every slot is busy so that issue stalls.

Every slot watches a single result bus, which carries a tag and a value. A slot that is waiting on the broadcast tag captures the value and marks that operand ready. One broadcast can satisfy both operands of a slot in the same cycle. An instruction that names a producer at the moment that producer broadcasts takes the value straight from the bus, so no wakeup is lost. Slots whose operands are both ready compete for a single dispatch port, and the lowest-indexed slot wins. A slot stays busy after dispatch until the result bus carries its own tag.

Top module: `rs_array`

## Requirements
- R1: The tag width is TAG_W = ceil(log2(NUM_TAGS)). Slot i carries the fixed tag TAG_BASE+i, which is never zero. A tag value of 0 on an operand means that operand is ready.
- R2: `issue_ready_o` is high exactly when at least one slot is free. `issue_tag_o` gives the tag of the lowest-numbered free slot, and an accepted issue is written into that slot.
- R3: When every slot is busy, `issue_ready_o` is low and an issue request leaves every slot unchanged.
- R4: An operand issued with tag 0 keeps its issued value. A slot whose two operand tags are both 0 requests dispatch starting in the cycle after issue.
- R5: When `cdb_valid_i` is high and `cdb_tag_i` equals the nonzero tag of a waiting operand in a busy slot, that operand takes `cdb_value_i` and its tag becomes 0.
- R6: When both operand tags of a slot name the broadcasting station, both operands capture the same value on the same edge.
- R7: An issued operand tag that equals the tag broadcast in the same cycle is stored as ready, with the broadcast value in place of the issued value.
- R8: When at least one slot requests, `disp_valid_o` is high and the port presents the lowest-indexed requesting slot (its tag, opcode and both operands). A slot is granted when `disp_ready_i` is high, at most one grant occurs per cycle, and a granted slot never requests again before it is freed.
- R9: A slot is freed only by a broadcast of its own tag after it has been dispatched. A broadcast of its tag before dispatch leaves it busy.
- R10: After the asynchronous active-low reset, every slot is free, `disp_valid_o` is low and `issue_tag_o` equals TAG_BASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_op_i | input | OP_W | Opcode of the issued instruction |
| issue_qj_i | input | TAG_W | Producer tag of the first operand, 0 if ready |
| issue_vj_i | input | DATA_W | First operand value, used when its tag is 0 |
| issue_qk_i | input | TAG_W | Producer tag of the second operand, 0 if ready |
| issue_vk_i | input | DATA_W | Second operand value, used when its tag is 0 |
| issue_ready_o | output | 1 | A free slot exists |
| issue_tag_o | output | TAG_W | Tag of the slot an issue would fill |
| cdb_valid_i | input | 1 | Result broadcast present |
| cdb_tag_i | input | TAG_W | Tag of the broadcasting station |
| cdb_value_i | input | DATA_W | Broadcast result value |
| disp_ready_i | input | 1 | Functional unit accepts a dispatch |
| disp_valid_o | output | 1 | A slot is ready to dispatch |
| disp_tag_o | output | TAG_W | Tag of the dispatching slot |
| disp_op_o | output | OP_W | Opcode of the dispatching slot |
| disp_vj_o | output | DATA_W | First operand of the dispatching slot |
| disp_vk_o | output | DATA_W | Second operand of the dispatching slot |

## Verification
The bench builds the array with four slots, an eight-code tag space, a tag base of 2 and 16-bit values. This leaves tag 6 and tag 7 free to stand for foreign producers. With four slots, every one of the sixteen ready/waiting patterns across a full array can be swept. Each pattern exercises the dispatch order, refusal when the array is full, lowest-free reuse after partial release, and wakeup of the waiting remainder. Directed cases then cover the double capture, same-cycle forwarding into either operand, and a premature broadcast of a slot's own tag.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // width of an index over n items, at least one bit
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rs_pick_first.sv
module rs_pick_first #(
  parameter int N     = 4,
  parameter int IDX_W = rs_pkg::idx_bits(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o  = |req_i;
  assign onehot_o = found_o ? (N'(1) << idx_o) : '0;
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int               DATA_W = 32,
  parameter int               OP_W   = 6,
  parameter int               TAG_W  = 4,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   issue_op_i,
  input  logic [TAG_W-1:0]  issue_qj_i,
  input  logic [DATA_W-1:0] issue_vj_i,
  input  logic [TAG_W-1:0]  issue_qk_i,
  input  logic [DATA_W-1:0] issue_vk_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_value_i,
  input  logic              grant_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] vj_o,
  output logic [DATA_W-1:0] vk_o
);
  logic              busy_q, fired_q;
  logic [OP_W-1:0]   op_q;
  logic [TAG_W-1:0]  qj_q, qk_q;
  logic [DATA_W-1:0] vj_q, vk_q;

  logic fwd_j, fwd_k, hit_j, hit_k, done_own;
  assign fwd_j    = cdb_valid_i && (issue_qj_i != '0) && (cdb_tag_i == issue_qj_i);
  assign fwd_k    = cdb_valid_i && (issue_qk_i != '0) && (cdb_tag_i == issue_qk_i);
  assign hit_j    = cdb_valid_i && (qj_q != '0) && (cdb_tag_i == qj_q);
  assign hit_k    = cdb_valid_i && (qk_q != '0) && (cdb_tag_i == qk_q);
  assign done_own = cdb_valid_i && fired_q && (cdb_tag_i == MY_TAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      fired_q <= 1'b0;
      op_q    <= '0;
      qj_q    <= '0;
      qk_q    <= '0;
      vj_q    <= '0;
      vk_q    <= '0;
    end else if (alloc_i) begin
      busy_q  <= 1'b1;
      fired_q <= 1'b0;
      op_q    <= issue_op_i;
      qj_q    <= fwd_j ? '0 : issue_qj_i;
      vj_q    <= fwd_j ? cdb_value_i : issue_vj_i;
      qk_q    <= fwd_k ? '0 : issue_qk_i;
      vk_q    <= fwd_k ? cdb_value_i : issue_vk_i;
    end else if (busy_q) begin
      if (grant_i) fired_q <= 1'b1;
      if (done_own) begin
        busy_q  <= 1'b0;
        fired_q <= 1'b0;
      end
      if (hit_j) begin
        vj_q <= cdb_value_i;
        qj_q <= '0;
      end
      if (hit_k) begin
        vk_q <= cdb_value_i;
        qk_q <= '0;
      end
    end
  end

  assign busy_o = busy_q;
  assign req_o  = busy_q && !fired_q && (qj_q == '0) && (qk_q == '0);
  assign op_o   = op_q;
  assign vj_o   = vj_q;
  assign vk_o   = vk_q;

  assert_alloc_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !busy_q);
  assert_grant_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> req_o);
  assert_release_own_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cdb_valid_i && cdb_tag_i == MY_TAG));
  assert_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !alloc_i && cdb_valid_i && qj_q != '0 && cdb_tag_i == qj_q)
    |=> (qj_q == '0 && vj_q == $past(cdb_value_i)));
  assert_both_slots_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !alloc_i && cdb_valid_i && qj_q != '0 && qj_q == qk_q && cdb_tag_i == qj_q)
    |=> (qj_q == '0 && qk_q == '0 && vj_q == vk_q));
  assert_issue_fwd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && cdb_valid_i && issue_qk_i != '0 && cdb_tag_i == issue_qk_i)
    |=> (qk_q == '0 && vk_q == $past(cdb_value_i)));
endmodule

// File: rtl/rs_array.sv
module rs_array #(
  parameter int N_ENTRY  = 4,
  parameter int NUM_TAGS = 16,
  parameter int TAG_BASE = 1,
  parameter int DATA_W   = 32,
  parameter int OP_W     = 6,
  localparam int TAG_W   = rs_pkg::idx_bits(NUM_TAGS),
  localparam int IDX_W   = rs_pkg::idx_bits(N_ENTRY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [OP_W-1:0]   issue_op_i,
  input  logic [TAG_W-1:0]  issue_qj_i,
  input  logic [DATA_W-1:0] issue_vj_i,
  input  logic [TAG_W-1:0]  issue_qk_i,
  input  logic [DATA_W-1:0] issue_vk_i,
  output logic              issue_ready_o,
  output logic [TAG_W-1:0]  issue_tag_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_value_i,
  input  logic              disp_ready_i,
  output logic              disp_valid_o,
  output logic [TAG_W-1:0]  disp_tag_o,
  output logic [OP_W-1:0]   disp_op_o,
  output logic [DATA_W-1:0] disp_vj_o,
  output logic [DATA_W-1:0] disp_vk_o
);
  logic [N_ENTRY-1:0] busy_vec, free_vec, req_vec, alloc_vec, grant_vec;
  logic [N_ENTRY-1:0] free_hot, req_hot;
  logic [IDX_W-1:0]   free_idx, disp_idx;
  logic               any_free, any_req;
  logic [OP_W-1:0]    op_arr [N_ENTRY];
  logic [DATA_W-1:0]  vj_arr [N_ENTRY];
  logic [DATA_W-1:0]  vk_arr [N_ENTRY];

  assign free_vec = ~busy_vec;

  rs_pick_first #(.N(N_ENTRY), .IDX_W(IDX_W)) u_free_pick (
    .req_i(free_vec), .found_o(any_free), .idx_o(free_idx), .onehot_o(free_hot)
  );
  rs_pick_first #(.N(N_ENTRY), .IDX_W(IDX_W)) u_disp_pick (
    .req_i(req_vec), .found_o(any_req), .idx_o(disp_idx), .onehot_o(req_hot)
  );

  assign alloc_vec = (issue_valid_i && any_free) ? free_hot : '0;
  assign grant_vec = disp_ready_i ? req_hot : '0;

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_slot
    rs_entry #(
      .DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W),
      .MY_TAG(TAG_W'(TAG_BASE + g))
    ) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (alloc_vec[g]),
      .issue_op_i (issue_op_i),
      .issue_qj_i (issue_qj_i),
      .issue_vj_i (issue_vj_i),
      .issue_qk_i (issue_qk_i),
      .issue_vk_i (issue_vk_i),
      .cdb_valid_i(cdb_valid_i),
      .cdb_tag_i  (cdb_tag_i),
      .cdb_value_i(cdb_value_i),
      .grant_i    (grant_vec[g]),
      .busy_o     (busy_vec[g]),
      .req_o      (req_vec[g]),
      .op_o       (op_arr[g]),
      .vj_o       (vj_arr[g]),
      .vk_o       (vk_arr[g])
    );
  end

  assign issue_ready_o = any_free;
  assign issue_tag_o   = TAG_W'(TAG_BASE) + TAG_W'(free_idx);
  assign disp_valid_o  = any_req;
  assign disp_tag_o    = TAG_W'(TAG_BASE) + TAG_W'(disp_idx);
  assign disp_op_o     = op_arr[disp_idx];
  assign disp_vj_o     = vj_arr[disp_idx];
  assign disp_vk_o     = vk_arr[disp_idx];

  assert_one_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_vec));
  assert_full_refuse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&busy_vec) |-> (!issue_ready_o && alloc_vec == '0));
  assert_issue_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_ready_o) |=> ($countones(busy_vec) >= 1));
endmodule

// File: tb/rs_array_bench.sv
module rs_array_bench;
  localparam int N  = 4;
  localparam int NT = 8;
  localparam int TB = 2;
  localparam int DW = 16;
  localparam int OW = 4;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          issue_valid;
  logic [OW-1:0] issue_op;
  logic [TW-1:0] issue_qj, issue_qk;
  logic [DW-1:0] issue_vj, issue_vk;
  logic          issue_ready;
  logic [TW-1:0] issue_tag;
  logic          cdb_valid;
  logic [TW-1:0] cdb_tag;
  logic [DW-1:0] cdb_value;
  logic          disp_ready, disp_valid;
  logic [TW-1:0] disp_tag;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_vj, disp_vk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rs_array #(.N_ENTRY(N), .NUM_TAGS(NT), .TAG_BASE(TB), .DATA_W(DW), .OP_W(OW)) u_rs_array (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid), .issue_op_i(issue_op),
    .issue_qj_i(issue_qj), .issue_vj_i(issue_vj),
    .issue_qk_i(issue_qk), .issue_vk_i(issue_vk),
    .issue_ready_o(issue_ready), .issue_tag_o(issue_tag),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_value_i(cdb_value),
    .disp_ready_i(disp_ready), .disp_valid_o(disp_valid), .disp_tag_o(disp_tag),
    .disp_op_o(disp_op), .disp_vj_o(disp_vj), .disp_vk_o(disp_vk)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_issue(input logic [OW-1:0] op, input logic [TW-1:0] qj, input logic [DW-1:0] vj,
                          input logic [TW-1:0] qk, input logic [DW-1:0] vk);
    issue_valid = 1'b1; issue_op = op;
    issue_qj = qj; issue_vj = vj; issue_qk = qk; issue_vk = vk;
    step();
    issue_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TW-1:0] tag, input logic [DW-1:0] val);
    cdb_valid = 1'b1; cdb_tag = tag; cdb_value = val;
    step();
    cdb_valid = 1'b0;
  endtask

  task automatic expect_disp(input string r, input int tag, input logic [OW-1:0] op,
                             input logic [DW-1:0] vj, input logic [DW-1:0] vk);
    chk({r, " disp_valid"}, 32'(disp_valid), 32'd1);
    chk({r, " disp_tag"}, 32'(disp_tag), 32'(tag));
    chk({r, " disp_op"}, 32'(disp_op), 32'(op));
    chk({r, " disp_vj"}, 32'(disp_vj), 32'(vj));
    chk({r, " disp_vk"}, 32'(disp_vk), 32'(vk));
    step();
  endtask

  function automatic int lowest_set(input logic [3:0] m);
    for (int i = 3; i >= 0; i--) if (m[i]) lowest_set = i;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; issue_valid = 1'b0; issue_op = '0;
    issue_qj = '0; issue_qk = '0; issue_vj = '0; issue_vk = '0;
    cdb_valid = 1'b0; cdb_tag = '0; cdb_value = '0; disp_ready = 1'b0;
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R10 R1: empty array, first tag is the base
    chk("R10 issue_ready", 32'(issue_ready), 32'd1);
    chk("R10 R1 issue_tag", 32'(issue_tag), 32'(TB));
    chk("R10 disp_valid", 32'(disp_valid), 32'd0);

    // sweep: bit i of m set -> slot i issued ready, else waits on foreign tag 7
    for (int m = 0; m < 16; m++) begin
      logic [3:0] mk;
      logic [DW-1:0] w;
      mk = 4'(m);
      w  = 16'hA000 | 16'(m);
      disp_ready = 1'b0;
      for (int i = 0; i < N; i++) begin
        chk("R2 R1 issue_tag lowest free", 32'(issue_tag), 32'(TB + i));
        do_issue(4'(m + i), mk[i] ? 3'd0 : 3'd7, 16'(m * 256 + i), 3'd0, 16'(256 + i));
      end
      chk("R3 full refuses", 32'(issue_ready), 32'd0);
      do_issue(4'hF, 3'd0, 16'hDEAD, 3'd0, 16'hBEEF);
      disp_ready = 1'b1;
      for (int i = 0; i < N; i++)
        if (mk[i]) expect_disp("R4 R8 ready order", TB + i, 4'(m + i), 16'(m * 256 + i), 16'(256 + i));
      chk("R8 no re-request", 32'(disp_valid), 32'd0);
      for (int i = 0; i < N; i++)
        if (mk[i]) bcast(3'(TB + i), 16'h0);
      if (mk == 4'd0) chk("R3 still full", 32'(issue_ready), 32'd0);
      else chk("R9 R2 freed lowest", 32'(issue_tag), 32'(TB + lowest_set(mk)));
      bcast(3'd7, w);
      for (int i = 0; i < N; i++)
        if (!mk[i]) expect_disp("R5 wakeup", TB + i, 4'(m + i), w, 16'(256 + i));
      chk("R8 drained", 32'(disp_valid), 32'd0);
      for (int i = 0; i < N; i++)
        if (!mk[i]) bcast(3'(TB + i), 16'h0);
      chk("R2 all free", 32'(issue_ready), 32'd1);
      chk("R3 bogus issue left no slot", 32'(issue_tag), 32'(TB));
    end

    // R6: both operands wait on tag 7
    disp_ready = 1'b1;
    do_issue(4'd3, 3'd7, 16'h0, 3'd7, 16'h0);
    chk("R6 waiting", 32'(disp_valid), 32'd0);
    bcast(3'd7, 16'h1234);
    expect_disp("R6 double capture", TB, 4'd3, 16'h1234, 16'h1234);
    bcast(3'(TB), 16'h0);

    // R7: forwarding into first operand
    cdb_valid = 1'b1; cdb_tag = 3'd6; cdb_value = 16'h0055;
    do_issue(4'd5, 3'd6, 16'h0, 3'd0, 16'h0077);
    cdb_valid = 1'b0;
    expect_disp("R7 R4 forward j", TB, 4'd5, 16'h0055, 16'h0077);
    bcast(3'(TB), 16'h0);
    // R7: forwarding into second operand
    cdb_valid = 1'b1; cdb_tag = 3'd6; cdb_value = 16'h0066;
    do_issue(4'd6, 3'd0, 16'h0011, 3'd6, 16'h0);
    cdb_valid = 1'b0;
    expect_disp("R7 forward k", TB, 4'd6, 16'h0011, 16'h0066);
    bcast(3'(TB), 16'h0);

    // R9: own tag broadcast before dispatch must not free
    disp_ready = 1'b0;
    do_issue(4'd1, 3'd0, 16'h0011, 3'd0, 16'h0022);
    bcast(3'(TB), 16'h0);
    chk("R9 early own tag keeps busy", 32'(issue_tag), 32'(TB + 1));
    disp_ready = 1'b1;
    expect_disp("R9 dispatch", TB, 4'd1, 16'h0011, 16'h0022);
    chk("R9 busy until broadcast", 32'(issue_tag), 32'(TB + 1));
    bcast(3'(TB), 16'h0);
    chk("R9 freed", 32'(issue_tag), 32'(TB));

    finish_run();
  end
endmodule